// File: doc/BRIEF.md
# SPI Card Register Block Reader

This engine sits on the host side of an SPI link to a flash memory card and fetches one of the card's two 128-bit descriptor registers: the identification register or the card-specific data register. A request names the register and the command index to send. The engine then runs the whole exchange through a byte-wide shifter. It sends a six-byte command frame and polls for the one-byte command response. It then waits for the data start token, collects 16 data bytes and verifies the 16-bit CRC that closes the block. The register contents arrive as an ordinary single-block data read. They are not carried inside the command response.

The access-time field of the card sits inside the very register being read, so the wait for the data token is limited by a fixed, parameterised byte count. The result is delivered together with a one-cycle done pulse and four status flags: CRC mismatch, bad response, timeout and bad token. Both registers are read with the same sequence of bytes. The register select only travels with the transaction and is echoed back with the result.

The byte path to the shifter is a valid/ready stream. A byte offered on `tx_data` stays put until `tx_ready` accepts it. After each accepted byte, the shifter returns exactly one received byte as a single-cycle `rx_valid` strobe. The engine never has more than one byte in flight. A request is accepted only while the engine is idle, which is signalled by `req_ready`.

Top module: `spi_regblk_reader`

## Requirements
- R1: After reset, `req_ready`=1, `cs_n`=1, `tx_valid`=0, `done`=0, all four flags are 0, `res_sel`=0 and `reg_value`=0.
- R2: The command frame is six bytes: `{2'b01, cmd}`, then four 0x00 argument bytes, then `{crc7, 1'b1}`. Here crc7 uses polynomial x^7+x^3+1 with initial value 0 and is computed MSB first over the first five bytes. Bytes received while the frame is being sent are ignored.
- R3: After the frame, the engine sends 0xFF and takes the first received byte with bit 7 clear as the response. A response on the 8th poll is accepted. Eight polls with bit 7 set raise `tmo_err` after exactly 14 bytes in total.
- R4: A response with any of bits 6..1 set ends the transaction after 7 bytes with `resp_err`. Bit 0 (the idle bit) may be either value.
- R5: While waiting for the token, 0xFF bytes are skipped. A token of 0xFE on the `DATA_TMO_BYTES`-th wait byte is accepted. `DATA_TMO_BYTES` bytes of 0xFF raise `tmo_err`. Any other byte raises `tok_err` at once.
- R6: The 16 data bytes are followed by a 2-byte CRC, high byte first. It is compared with a CRC16 (polynomial 0x1021, initial value 0, MSB first) computed over the data. On a mismatch, `crc_err` is set and `reg_value` is left unchanged.
- R7: On a CRC match, `reg_value` takes the data bytes with the first byte at bits 127:120. It changes in no other case.
- R8: Both register selects produce the same byte sequence and the same byte count (31 bytes with 3 response polls and 4 token bytes). `res_sel` echoes the select of the last accepted request.
- R9: `done` is high for exactly one cycle per transaction, with at most one flag set. The flags hold until the next request is accepted, and they read 0 from the cycle after acceptance.
- R10: A byte offered with `tx_ready` low is held with `tx_data` stable. `req_ready` is high only when the engine is idle with `cs_n` high and no byte offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request accepted |
| req_sel | input | 1 | Register select (0 identification, 1 card-specific) |
| req_cmd | input | 6 | Command index placed in the frame |
| cs_n | output | 1 | Card select, low during a transaction |
| tx_valid | output | 1 | Byte offered to the shifter |
| tx_ready | input | 1 | Shifter takes the offered byte |
| tx_data | output | 8 | Byte to send |
| rx_valid | input | 1 | Received byte strobe, one per sent byte |
| rx_data | input | 8 | Received byte |
| done | output | 1 | One-cycle end-of-transaction pulse |
| res_sel | output | 1 | Select of the last accepted request |
| reg_value | output | 128 | Last register value read with a good CRC |
| crc_err | output | 1 | Data CRC mismatch |
| resp_err | output | 1 | Response reported an error |
| tmo_err | output | 1 | Response or token wait exhausted |
| tok_err | output | 1 | Unexpected byte in place of the start token |

## Verification
The checker assumes that the shifter honours the byte handshake. It raises `rx_valid` for a single cycle only after a byte has been accepted, and at most once per accepted byte. It also assumes that `req_valid` changes only from the bench side of the clock. The bench models the shifter as one process that counts accepted bytes and answers each one after a chosen latency of 1 to 3 cycles. A stall pattern can be enabled on `tx_ready`. Card bytes come from a per-transaction script, so every stimulus remains a legal exchange while response position, token position, latency, back-pressure and data pattern are swept.

// File: rtl/spi_regblk_pkg.sv
package spi_regblk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_RESP,
    ST_TOKEN,
    ST_DATA,
    ST_CRC
  } rd_state_e;

  localparam logic [7:0] FILL_BYTE   = 8'hFF;
  localparam logic [7:0] START_TOKEN = 8'hFE;

  // one byte through the 7-bit command CRC, MSB first
  function automatic logic [6:0] crc7_step(input logic [6:0] c_in, input logic [7:0] d);
    logic [6:0] c;
    logic       fb;
    c = c_in;
    for (int i = 7; i >= 0; i--) begin
      fb = c[6] ^ d[i];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  // one byte through the 16-bit data CRC (0x1021), MSB first
  function automatic logic [15:0] crc16_step(input logic [15:0] c_in, input logic [7:0] d);
    logic [15:0] c;
    logic        fb;
    c = c_in;
    for (int i = 7; i >= 0; i--) begin
      fb = c[15] ^ d[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

endpackage

// File: rtl/spi_regblk_cmdframe.sv
module spi_regblk_cmdframe
  import spi_regblk_pkg::*;
#(
  parameter int ARG_BYTES = 4,
  parameter int IDX_W     = 3
) (
  input  logic [5:0]       cmd_idx,
  input  logic [IDX_W-1:0] byte_idx,
  output logic [7:0]       frame_byte
);
  localparam int FRAME_BYTES = ARG_BYTES + 2;

  logic [7:0] fbytes [FRAME_BYTES];
  logic [6:0] crc_acc;

  always_comb begin
    fbytes[0] = {2'b01, cmd_idx};
    for (int i = 1; i <= ARG_BYTES; i++) fbytes[i] = 8'h00;
    crc_acc = '0;
    for (int i = 0; i <= ARG_BYTES; i++) crc_acc = crc7_step(crc_acc, fbytes[i]);
    fbytes[FRAME_BYTES-1] = {crc_acc, 1'b1};
    frame_byte = FILL_BYTE;
    for (int i = 0; i < FRAME_BYTES; i++)
      if (byte_idx == IDX_W'(i)) frame_byte = fbytes[i];
  end
endmodule

// File: rtl/spi_regblk_crc16.sv
module spi_regblk_crc16
  import spi_regblk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc <= '0;
    else if (clear) crc <= '0;
    else if (en)    crc <= crc16_step(crc, din);
  end
endmodule

// File: rtl/spi_regblk_assembler.sv
module spi_regblk_assembler #(
  parameter int NBYTES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic [7:0]          din,
  input  logic                commit,
  output logic [NBYTES*8-1:0] value
);
  logic [7:0]          lane [NBYTES];
  logic [NBYTES*8-1:0] flat;

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane[g] <= '0;
      else if (shift_en) begin
        if (g == 0) lane[g] <= din;
        else        lane[g] <= lane[(g == 0) ? 0 : g-1];
      end
    end
    assign flat[g*8 +: 8] = lane[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      value <= '0;
    else if (commit) value <= flat;
  end
endmodule

// File: rtl/spi_regblk_reader.sv
module spi_regblk_reader
  import spi_regblk_pkg::*;
#(
  parameter int RESP_POLLS     = 8,
  parameter int DATA_TMO_BYTES = 256,
  parameter int REG_BYTES      = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_sel,
  input  logic [5:0]             req_cmd,
  output logic                   cs_n,
  output logic                   tx_valid,
  input  logic                   tx_ready,
  output logic [7:0]             tx_data,
  input  logic                   rx_valid,
  input  logic [7:0]             rx_data,
  output logic                   done,
  output logic                   res_sel,
  output logic [REG_BYTES*8-1:0] reg_value,
  output logic                   crc_err,
  output logic                   resp_err,
  output logic                   tmo_err,
  output logic                   tok_err
);
  localparam int ARG_BYTES   = 4;
  localparam int FRAME_BYTES = ARG_BYTES + 2;
  localparam int IDX_W       = $clog2(FRAME_BYTES);
  localparam int MAX_A       = (RESP_POLLS > DATA_TMO_BYTES) ? RESP_POLLS : DATA_TMO_BYTES;
  localparam int MAX_B       = (REG_BYTES > FRAME_BYTES) ? REG_BYTES : FRAME_BYTES;
  localparam int CNT_MAX     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W       = $clog2(CNT_MAX + 1);

  rd_state_e        state;
  logic             wait_rx;
  logic [CNT_W-1:0] cnt;
  logic [5:0]       cmd_q;
  logic [7:0]       crc_hi;
  logic [15:0]      crc_val;
  logic [7:0]       frame_byte;
  logic             rx_take;
  logic             crc_match;

  assign rx_take   = (state != ST_IDLE) && wait_rx && rx_valid;
  assign crc_match = ({crc_hi, rx_data} == crc_val);

  assign req_ready = (state == ST_IDLE);
  assign cs_n      = (state == ST_IDLE);
  assign tx_valid  = (state != ST_IDLE) && !wait_rx;
  assign tx_data   = (state == ST_CMD) ? frame_byte : FILL_BYTE;

  spi_regblk_cmdframe #(.ARG_BYTES(ARG_BYTES), .IDX_W(IDX_W)) u_frame (
    .cmd_idx   (cmd_q),
    .byte_idx  (cnt[IDX_W-1:0]),
    .frame_byte(frame_byte)
  );

  spi_regblk_crc16 u_crc (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(state == ST_TOKEN),
    .en   (rx_take && state == ST_DATA),
    .din  (rx_data),
    .crc  (crc_val)
  );

  spi_regblk_assembler #(.NBYTES(REG_BYTES)) u_asm (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(rx_take && state == ST_DATA),
    .din     (rx_data),
    .commit  (rx_take && state == ST_CRC && cnt != '0 && crc_match),
    .value   (reg_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      wait_rx  <= 1'b0;
      cnt      <= '0;
      cmd_q    <= '0;
      crc_hi   <= '0;
      done     <= 1'b0;
      res_sel  <= 1'b0;
      crc_err  <= 1'b0;
      resp_err <= 1'b0;
      tmo_err  <= 1'b0;
      tok_err  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_IDLE) begin
        if (req_valid) begin
          cmd_q    <= req_cmd;
          res_sel  <= req_sel;
          cnt      <= '0;
          wait_rx  <= 1'b0;
          crc_err  <= 1'b0;
          resp_err <= 1'b0;
          tmo_err  <= 1'b0;
          tok_err  <= 1'b0;
          state    <= ST_CMD;
        end
      end else if (!wait_rx) begin
        if (tx_ready) wait_rx <= 1'b1;
      end else if (rx_valid) begin
        wait_rx <= 1'b0;
        unique case (state)
          ST_CMD: begin
            if (cnt == CNT_W'(FRAME_BYTES-1)) begin
              cnt   <= '0;
              state <= ST_RESP;
            end else cnt <= cnt + 1'b1;
          end
          ST_RESP: begin
            if (!rx_data[7]) begin
              cnt <= '0;
              if (rx_data[6:1] != 6'd0) begin
                resp_err <= 1'b1;
                done     <= 1'b1;
                state    <= ST_IDLE;
              end else state <= ST_TOKEN;
            end else if (cnt == CNT_W'(RESP_POLLS-1)) begin
              tmo_err <= 1'b1;
              done    <= 1'b1;
              state   <= ST_IDLE;
            end else cnt <= cnt + 1'b1;
          end
          ST_TOKEN: begin
            if (rx_data == START_TOKEN) begin
              cnt   <= '0;
              state <= ST_DATA;
            end else if (rx_data == FILL_BYTE) begin
              if (cnt == CNT_W'(DATA_TMO_BYTES-1)) begin
                tmo_err <= 1'b1;
                done    <= 1'b1;
                state   <= ST_IDLE;
              end else cnt <= cnt + 1'b1;
            end else begin
              tok_err <= 1'b1;
              done    <= 1'b1;
              state   <= ST_IDLE;
            end
          end
          ST_DATA: begin
            if (cnt == CNT_W'(REG_BYTES-1)) begin
              cnt   <= '0;
              state <= ST_CRC;
            end else cnt <= cnt + 1'b1;
          end
          ST_CRC: begin
            if (cnt == '0) begin
              crc_hi <= rx_data;
              cnt    <= cnt + 1'b1;
            end else begin
              crc_err <= !crc_match;
              done    <= 1'b1;
              state   <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_regblk_chk.sv
module spi_regblk_chk #(
  parameter int VW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          cs_n,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          done,
  input logic [VW-1:0] reg_value,
  input logic          crc_err,
  input logic          resp_err,
  input logic          tmo_err,
  input logic          tok_err
);
  a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n && !tx_valid));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot0({crc_err, resp_err, tmo_err, tok_err}));

  a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> (done || $stable({crc_err, resp_err, tmo_err, tok_err})));

  a_r7_value_on_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_value) |-> (done && !crc_err && !resp_err && !tmo_err && !tok_err));
endmodule

bind spi_regblk_reader spi_regblk_chk #(.VW(REG_BYTES*8)) u_chk (.*);

// File: tb/spi_regblk_reader_tb.sv
`timescale 1ns/1ps
module spi_regblk_reader_tb;
  localparam int TMO = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_sel = 1'b0;
  logic [5:0]   req_cmd = '0;
  logic         cs_n;
  logic         tx_valid;
  logic         tx_ready = 1'b0;
  logic [7:0]   tx_data;
  logic         rx_valid = 1'b0;
  logic [7:0]   rx_data = '0;
  logic         done;
  logic         res_sel;
  logic [127:0] reg_value;
  logic         crc_err, resp_err, tmo_err, tok_err;

  always #4 clk = ~clk;

  spi_regblk_reader #(.RESP_POLLS(8), .DATA_TMO_BYTES(TMO), .REG_BYTES(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_cmd(req_cmd), .cs_n(cs_n), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data),
    .done(done), .res_sel(res_sel), .reg_value(reg_value), .crc_err(crc_err),
    .resp_err(resp_err), .tmo_err(tmo_err), .tok_err(tok_err)
  );

  int total = 0;
  int bad = 0;

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // shifter model
  logic [7:0] card [0:63];
  int card_len = 0;
  int card_base = 0;
  int card_k = 0;
  logic [7:0] txlog [0:255];
  int n_tx = 0;
  int n_served = 0;
  int pend = 0;
  int lat = 1;
  int stall_mode = 0;
  int cyc = 0;

  always @(posedge clk) begin
    if (tx_valid && tx_ready) begin
      txlog[n_tx % 256] <= tx_data;
      n_tx <= n_tx + 1;
    end
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    rx_valid = 1'b0;
    if (n_tx > n_served) begin
      n_served = n_served + 1;
      pend = lat;
    end else if (pend > 0) begin
      pend = pend - 1;
      if (pend == 0) begin
        rx_valid = 1'b1;
        rx_data = (card_k - card_base < card_len) ? card[card_k - card_base] : 8'hFF;
        card_k = card_k + 1;
      end
    end
    tx_ready = (stall_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
  end

  function automatic logic [6:0] ref_crc7(input logic [39:0] v);
    logic [6:0] c = '0;
    for (int i = 39; i >= 0; i--) begin
      logic b = c[6] ^ v[i];
      c = {c[5:0], 1'b0} ^ (b ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  function automatic logic [15:0] ref_crc16(input logic [127:0] v);
    logic [15:0] c = '0;
    for (int i = 127; i >= 0; i--) begin
      logic b = c[15] ^ v[i];
      c = {c[14:0], 1'b0} ^ (b ? 16'h1021 : 16'h0000);
    end
    return c;
  endfunction

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 37) + (i * 11) + (i * i) + 5);
  endfunction

  task automatic push(input logic [7:0] b);
    card[card_len] = b;
    card_len++;
  endtask

  // script: 6 ignored bytes, polls, response, token wait, token, data, crc
  task automatic build(input int seed, input int n_rff, input logic [7:0] resp,
                       input int n_tff, input logic [7:0] tok, input bit bad_crc,
                       output logic [127:0] val);
    logic [15:0] c;
    card_len = 0;
    for (int i = 0; i < 6; i++) push(8'h00);
    for (int i = 0; i < n_rff; i++) push(8'hFF);
    push(resp);
    for (int i = 0; i < n_tff; i++) push(8'hFF);
    push(tok);
    for (int i = 0; i < 16; i++) begin
      val[127 - i*8 -: 8] = pat(seed, i);
      push(pat(seed, i));
    end
    c = ref_crc16(val);
    push(c[15:8]);
    push(c[7:0] ^ (bad_crc ? 8'h01 : 8'h00));
  endtask

  int tx_base;
  task automatic do_read(input bit sel, input logic [5:0] idx, input int l, input int sm,
                         output int ntx);
    int guard;
    @(negedge clk);
    lat = l;
    stall_mode = sm;
    card_base = card_k;
    tx_base = n_tx;
    req_valid = 1'b1;
    req_sel = sel;
    req_cmd = idx;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 flags clear after accept", {crc_err, resp_err, tmo_err, tok_err}, 4'b0);
    guard = 0;
    while (!done && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    if (!done) check("R9 done within bound", 0, 1);
    ntx = n_tx - tx_base;
  endtask

  task automatic check_frame(input logic [5:0] idx, input string tag);
    logic [39:0] hdr = {2'b01, idx, 32'h0};
    check({tag, " frame byte0"}, txlog[tx_base % 256], {2'b01, idx});
    for (int i = 1; i < 5; i++) check({tag, " frame arg"}, txlog[(tx_base + i) % 256], 8'h00);
    check({tag, " frame crc7"}, txlog[(tx_base + 5) % 256], {ref_crc7(hdr), 1'b1});
    check({tag, " fill byte"}, txlog[(tx_base + 6) % 256], 8'hFF);
  endtask

  logic [127:0] expv, lastv;
  int ntx;

  initial begin
    #(200000 * 8);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset outputs", {req_ready, cs_n, tx_valid, done, res_sel},
          {1'b1, 1'b1, 1'b0, 1'b0, 1'b0});
    check("R1 reset flags", {crc_err, resp_err, tmo_err, tok_err}, 4'b0);
    check("R1 reset value", reg_value, 128'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R5 R6 R7 R8: card-specific register read
    build(1, 2, 8'h00, 3, 8'hFE, 1'b0, expv);
    do_read(1'b1, 6'd9, 1, 0, ntx);
    check_frame(6'd9, "R2");
    check("R7 value sel1", reg_value, expv);
    check("R6 no crc error", {crc_err, resp_err, tmo_err, tok_err}, 4'b0);
    check("R8 byte count sel1", ntx, 31);
    check("R8 sel echo 1", res_sel, 1'b1);

    // R8 R10: identification register, slow shifter, stalls
    build(2, 2, 8'h00, 3, 8'hFE, 1'b0, expv);
    do_read(1'b0, 6'd10, 3, 1, ntx);
    check_frame(6'd10, "R10");
    check("R7 value sel0", reg_value, expv);
    check("R8 byte count sel0", ntx, 31);
    check("R8 sel echo 0", res_sel, 1'b0);

    // sweep: response and token positions up to the bounds, both selects
    for (int s = 3; s < 43; s++) begin
      int nr = s % 8;
      int nt = s % TMO;
      bit sl = s[0];
      build(s, nr, (s % 3 == 0) ? 8'h01 : 8'h00, nt, 8'hFE, 1'b0, expv);
      do_read(sl, sl ? 6'd9 : 6'd10, 1 + (s % 3), (s / 2) % 2, ntx);
      check("R3 R5 sweep value", reg_value, expv);
      check("R4 sweep flags", {crc_err, resp_err, tmo_err, tok_err}, 4'b0);
      check("R8 sweep count", ntx, 6 + nr + 1 + nt + 1 + 16 + 2);
      check_frame(sl ? 6'd9 : 6'd10, "R2 sweep");
    end
    lastv = reg_value;

    // R6 crc mismatch keeps the old value
    build(50, 0, 8'h00, 0, 8'hFE, 1'b1, expv);
    do_read(1'b1, 6'd9, 2, 0, ntx);
    check("R6 crc_err", {crc_err, resp_err, tmo_err, tok_err}, 4'b1000);
    check("R6 value kept", reg_value, lastv);

    // R4 response errors
    build(51, 1, 8'h04, 0, 8'hFE, 1'b0, expv);
    do_read(1'b1, 6'd9, 1, 0, ntx);
    check("R4 resp_err 0x04", {crc_err, resp_err, tmo_err, tok_err}, 4'b0100);
    check("R4 count 0x04", ntx, 8);
    build(52, 0, 8'h40, 0, 8'hFE, 1'b0, expv);
    do_read(1'b0, 6'd10, 1, 1, ntx);
    check("R4 resp_err 0x40", {crc_err, resp_err, tmo_err, tok_err}, 4'b0100);
    check("R4 count 0x40", ntx, 7);
    check("R7 value kept resp", reg_value, lastv);

    // R3 response timeout: eight polls all with bit 7 set
    card_len = 0;
    for (int i = 0; i < 6; i++) push(8'h00);
    for (int i = 0; i < 8; i++) push(8'h80 | 8'(i));
    do_read(1'b1, 6'd9, 1, 0, ntx);
    check("R3 tmo_err", {crc_err, resp_err, tmo_err, tok_err}, 4'b0010);
    check("R3 count", ntx, 14);

    // R5 token timeout
    build(53, 0, 8'h00, TMO, 8'hFE, 1'b0, expv);
    do_read(1'b1, 6'd9, 1, 0, ntx);
    check("R5 tmo_err", {crc_err, resp_err, tmo_err, tok_err}, 4'b0010);
    check("R5 count", ntx, 6 + 1 + TMO);
    check("R7 value kept tmo", reg_value, lastv);

    // R5 bad token
    build(54, 0, 8'h00, 2, 8'hFC, 1'b0, expv);
    do_read(1'b0, 6'd10, 2, 0, ntx);
    check("R5 tok_err", {crc_err, resp_err, tmo_err, tok_err}, 4'b0001);
    check("R5 count tok", ntx, 6 + 1 + 3);

    // R9 flags hold while idle, then clear on next request
    repeat (10) @(negedge clk);
    check("R9 flags hold", {crc_err, resp_err, tmo_err, tok_err}, 4'b0001);
    check("R9 done low idle", done, 1'b0);
    @(negedge clk);
    check("R10 idle quiet", {req_ready, cs_n, tx_valid}, 3'b110);
    build(55, 0, 8'h00, 0, 8'hFE, 1'b0, expv);
    do_read(1'b1, 6'd9, 1, 1, ntx);
    check("R7 value final", reg_value, expv);
    @(negedge clk);
    check("R9 done one cycle", done, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule